// File: doc/BRIEF.md
# Upper-Memory Flash Window Mapper

This block sits on an 8-bit host bus with a 20-bit memory address and decides which host memory cycles belong to a 512 KB parallel flash. The flash is treated as 32 banks of 16 KB. The top 256 KB of host memory, from C0000 to FFFFF, is treated as 16 windows of 16 KB. The block maps selected windows onto flash banks. For every claimed cycle it drives the flash chip select and the flash address. It also drives an acknowledge that tells the bus the card has taken the cycle.

Two mappings are fixed:

- The disk BIOS lives in flash bank 0. A strap pin places it at D0000 or at E0000.
- A replacement system ROM lives in banks 1 and 2. It covers F8000 to FFFFF, and only when a switch input enables it.

Those fixed mappings use 48 KB of flash. The other banks hold cartridge images or ROM-disk images. Software brings such an image into view by writing one of four window registers through I/O ports. Each register holds an enable bit, a window index and a bank number.

Flash writes reach the flash only when software has set a write-enable bit in a control port. Otherwise memory writes to mapped windows are dropped.

Top module: `flash_window_mapper`

## Requirements
- R1: After reset, all four register windows are disabled and the flash write-enable bit is clear. Only the fixed mappings decode.
- R2: With `biosAtE` = 0, addresses D0000–D3FFF map to flash bank 0. With `biosAtE` = 1, addresses E0000–E3FFF map to bank 0 instead.
- R3: With `sysRomEn` = 1, F8000–FBFFF map to bank 1 and FC000–FFFFF map to bank 2. With `sysRomEn` = 0, no fixed mapping claims those addresses.
- R4: Window register k (k = 0..3) is written at two I/O ports. At `IO_BASE`+2k, data bits 4:0 set its bank number. At `IO_BASE`+2k+1, data bit 7 sets its enable and bits 3:0 set its window index w. Window w covers host addresses C0000 + w·4000h up to C0000 + w·4000h + 3FFFh.
- R5: When a mapping matches, `flashAddr` equals {bank[4:0], memAddr[13:0]}. When no mapping matches, `flashAddr` is 0. The output follows the address in the same cycle.
- R6: When several mappings match, the BIOS mapping wins, then the system-ROM mapping, then register window 0, 1, 2 and 3, in that order.
- R7: Any address below C0000 is never claimed. A matching read asserts `flashCs` and `decodeAck`. With no match, both stay low.
- R8: Data bit 0 written to port `IO_BASE`+8 sets the flash write-enable bit. With that bit set, a memory write to a matching address asserts `flashCs`, `flashWe` and `decodeAck`. With it clear, such a write asserts none of the three.
- R9: Changes take effect on the clock edge that samples the I/O write. The following are ignored and change no mapping:
  - I/O writes with `ioWr` low;
  - writes to ports outside `IO_BASE`..`IO_BASE`+8;
  - register bits not named in R4 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | input | 20 | Host memory address |
| memRd | input | 1 | Host memory read cycle |
| memWr | input | 1 | Host memory write cycle |
| ioWr | input | 1 | Host I/O write strobe |
| ioAddr | input | 16 | Host I/O port address |
| ioData | input | 8 | Host I/O write data |
| biosAtE | input | 1 | Strap: BIOS window at E0000 instead of D0000 |
| sysRomEn | input | 1 | Switch: enable system-ROM mapping |
| flashCs | output | 1 | Flash chip select |
| flashWe | output | 1 | Flash write enable |
| flashAddr | output | 19 | Flash byte address {bank, offset} |
| decodeAck | output | 1 | Card claims the current memory cycle |

## Verification
The bench places register windows on the BIOS window index and on the system-ROM windows, and points two register windows at the same index. This catches a priority chain that is reversed or that lets a register override a fixed mapping; such a design would present the wrong bank in `flashAddr`. It toggles the strap and the switch to catch a fixed window that is hard-wired or ignores its enable. It also probes addresses just below C0000, where a decoder that drops the top address bits would claim ordinary RAM. It issues writes before and after setting the write-enable bit, and writes to the port just past the control port. A design that passes writes freely, or decodes ports too loosely, shows a spurious `flashWe` or a register that changed.

// File: rtl/flash_win_pkg.sv
package flash_win_pkg;
  localparam int NUM_WIN      = 4;
  localparam int BANK_W       = 5;
  localparam int IDX_W        = 4;
  localparam int OFS_W        = 14;
  localparam int ADDR_W       = 20;
  localparam int IO_ADDR_W    = 16;
  localparam int IO_DATA_W    = 8;
  localparam int FLASH_ADDR_W = BANK_W + OFS_W;

  typedef struct packed {
    logic [NUM_WIN-1:0] bankWr;
    logic [NUM_WIN-1:0] attrWr;
    logic               ctrlWr;
  } regStrobe_t;
endpackage

// File: rtl/fwm_ctrl.sv
module fwm_ctrl
  import flash_win_pkg::*;
#(
  parameter logic [IO_ADDR_W-1:0] IO_BASE = 16'h0300
) (
  input  logic                 ioWr,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic                 memRd,
  input  logic                 memWr,
  input  logic                 hit,
  input  logic                 wrEnQ,
  output regStrobe_t           strobe,
  output logic                 flashCs,
  output logic                 flashWe,
  output logic                 decodeAck
);
  localparam logic [IO_ADDR_W-1:0] CTRL_OFS = IO_ADDR_W'(2 * NUM_WIN);

  logic [IO_ADDR_W-1:0] portOfs;
  logic                 serviced;

  assign portOfs = ioAddr - IO_BASE;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_port
    localparam logic [IO_ADDR_W-1:0] BANK_OFS = IO_ADDR_W'(2 * k);
    localparam logic [IO_ADDR_W-1:0] ATTR_OFS = IO_ADDR_W'(2 * k + 1);
    assign strobe.bankWr[k] = ioWr && (portOfs == BANK_OFS);
    assign strobe.attrWr[k] = ioWr && (portOfs == ATTR_OFS);
  end
  assign strobe.ctrlWr = ioWr && (portOfs == CTRL_OFS);

  // Reads always serviced on a hit; writes only when write-enable is set.
  always_comb begin
    serviced  = hit && (memRd || (memWr && wrEnQ));
    flashCs   = serviced;
    flashWe   = serviced && memWr;
    decodeAck = serviced;
  end
endmodule

// File: rtl/fwm_datapath.sv
module fwm_datapath
  import flash_win_pkg::*;
#(
  parameter logic [BANK_W-1:0] BIOS_BANK = 5'd0,
  parameter logic [BANK_W-1:0] SYS_BANK  = 5'd1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrobe_t              strobe,
  input  logic [IO_DATA_W-1:0]    ioData,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic                    biosAtE,
  input  logic                    sysRomEn,
  output logic                    hit,
  output logic [FLASH_ADDR_W-1:0] flashAddr,
  output logic                    wrEnQ
);
  localparam int UPPER_W = ADDR_W - OFS_W - IDX_W;
  localparam logic [UPPER_W-1:0] UPPER_TAG = {UPPER_W{1'b1}};
  localparam logic [ADDR_W-1:0]  AREA_BASE = 20'hC0000;
  localparam logic [IDX_W-1:0]   BIOS_IDX_D = IDX_W'((20'hD0000 - AREA_BASE) >> OFS_W);
  localparam logic [IDX_W-1:0]   BIOS_IDX_E = IDX_W'((20'hE0000 - AREA_BASE) >> OFS_W);
  localparam logic [IDX_W-1:0]   SYS_IDX_LO = IDX_W'((20'hF8000 - AREA_BASE) >> OFS_W);
  localparam logic [IDX_W-1:0]   SYS_IDX_HI = IDX_W'((20'hFC000 - AREA_BASE) >> OFS_W);

  logic [NUM_WIN-1:0] enQ;
  logic [IDX_W-1:0]   idxQ  [NUM_WIN];
  logic [BANK_W-1:0]  bankQ [NUM_WIN];
  logic [NUM_WIN-1:0] winHit;

  logic               inArea;
  logic [IDX_W-1:0]   winIdx;
  logic               biosHit;
  logic               sysHitLo;
  logic               sysHitHi;
  logic [BANK_W-1:0]  selBank;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ[k]   <= 1'b0;
        idxQ[k]  <= '0;
        bankQ[k] <= '0;
      end else begin
        if (strobe.bankWr[k]) bankQ[k] <= ioData[BANK_W-1:0];
        if (strobe.attrWr[k]) begin
          enQ[k]  <= ioData[IO_DATA_W-1];
          idxQ[k] <= ioData[IDX_W-1:0];
        end
      end
    end
    assign winHit[k] = enQ[k] && inArea && (idxQ[k] == winIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              wrEnQ <= 1'b0;
    else if (strobe.ctrlWr) wrEnQ <= ioData[0];
  end

  assign inArea   = (memAddr[ADDR_W-1 -: UPPER_W] == UPPER_TAG);
  assign winIdx   = memAddr[OFS_W +: IDX_W];
  assign biosHit  = inArea && (winIdx == (biosAtE ? BIOS_IDX_E : BIOS_IDX_D));
  assign sysHitLo = inArea && sysRomEn && (winIdx == SYS_IDX_LO);
  assign sysHitHi = inArea && sysRomEn && (winIdx == SYS_IDX_HI);

  // Priority: BIOS, system ROM, then register windows low index first.
  always_comb begin
    hit     = 1'b0;
    selBank = '0;
    for (int k = NUM_WIN - 1; k >= 0; k--) begin
      if (winHit[k]) begin
        hit     = 1'b1;
        selBank = bankQ[k];
      end
    end
    if (sysHitHi) begin
      hit     = 1'b1;
      selBank = SYS_BANK + BANK_W'(1);
    end
    if (sysHitLo) begin
      hit     = 1'b1;
      selBank = SYS_BANK;
    end
    if (biosHit) begin
      hit     = 1'b1;
      selBank = BIOS_BANK;
    end
  end

  assign flashAddr = hit ? {selBank, memAddr[OFS_W-1:0]} : '0;
endmodule

// File: rtl/flash_window_mapper.sv
module flash_window_mapper
  import flash_win_pkg::*;
#(
  parameter logic [IO_ADDR_W-1:0] IO_BASE   = 16'h0300,
  parameter logic [BANK_W-1:0]    BIOS_BANK = 5'd0,
  parameter logic [BANK_W-1:0]    SYS_BANK  = 5'd1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic                    memRd,
  input  logic                    memWr,
  input  logic                    ioWr,
  input  logic [IO_ADDR_W-1:0]    ioAddr,
  input  logic [IO_DATA_W-1:0]    ioData,
  input  logic                    biosAtE,
  input  logic                    sysRomEn,
  output logic                    flashCs,
  output logic                    flashWe,
  output logic [FLASH_ADDR_W-1:0] flashAddr,
  output logic                    decodeAck
);
  regStrobe_t strobe;
  logic       hit;
  logic       wrEnQ;

  fwm_ctrl #(.IO_BASE(IO_BASE)) ctrl_i (
    .ioWr(ioWr), .ioAddr(ioAddr), .memRd(memRd), .memWr(memWr),
    .hit(hit), .wrEnQ(wrEnQ), .strobe(strobe),
    .flashCs(flashCs), .flashWe(flashWe), .decodeAck(decodeAck)
  );

  fwm_datapath #(.BIOS_BANK(BIOS_BANK), .SYS_BANK(SYS_BANK)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioData(ioData),
    .memAddr(memAddr), .biosAtE(biosAtE), .sysRomEn(sysRomEn),
    .hit(hit), .flashAddr(flashAddr), .wrEnQ(wrEnQ)
  );
endmodule

// File: rtl/fwm_checker.sv
module fwm_checker
  import flash_win_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       memAddr,
  input logic                    memRd,
  input logic                    memWr,
  input logic                    biosAtE,
  input logic                    flashCs,
  input logic                    flashWe,
  input logic [FLASH_ADDR_W-1:0] flashAddr,
  input logic                    decodeAck,
  input logic                    wrEnQ,
  input regStrobe_t              strobe
);
  logic biosAddr;
  assign biosAddr = (memAddr[19:14] == (biosAtE ? 6'b111000 : 6'b110100));

  // R1
  assert_reset_clears_wren_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !wrEnQ);

  // R2
  assert_bios_bank_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memWr && biosAddr) |-> (flashCs && flashAddr[18:14] == 5'd0));

  // R5
  assert_offset_passthru_R5: assert property (@(posedge clk) disable iff (!rstN)
    flashCs |-> (flashAddr[13:0] == memAddr[13:0]));

  // R7
  assert_low_memory_unclaimed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr[19:18] != 2'b11) |-> (!decodeAck && !flashCs));

  // R8
  assert_write_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    flashWe |-> (memWr && wrEnQ && flashCs));

  // R9
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

bind flash_window_mapper fwm_checker chk_i (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
  .biosAtE(biosAtE), .flashCs(flashCs), .flashWe(flashWe),
  .flashAddr(flashAddr), .decodeAck(decodeAck), .wrEnQ(wrEnQ), .strobe(strobe)
);

// File: tb/flash_window_mapper_tb_top.sv
module flash_window_mapper_tb_top;
  localparam logic [15:0] BASE = 16'h0300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] memAddr = '0;
  logic        memRd = 1'b0, memWr = 1'b0, ioWr = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioData = '0;
  logic        biosAtE = 1'b0, sysRomEn = 1'b0;
  logic        flashCs, flashWe, decodeAck;
  logic [18:0] flashAddr;

  int compared = 0;
  int mismatched = 0;

  logic       mEn   [4];
  logic [3:0] mIdx  [4];
  logic [4:0] mBank [4];
  logic       mWrEn;

  always #4 clk = ~clk;

  flash_window_mapper dut_i (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .ioWr(ioWr), .ioAddr(ioAddr), .ioData(ioData), .biosAtE(biosAtE),
    .sysRomEn(sysRomEn), .flashCs(flashCs), .flashWe(flashWe),
    .flashAddr(flashAddr), .decodeAck(decodeAck)
  );

  function automatic logic [21:0] expect_out(logic [19:0] a, logic rd, logic wr);
    logic hit = 1'b0;
    logic [4:0] bank = '0;
    logic [3:0] w = a[17:14];
    logic up = (a[19:18] == 2'b11);
    logic serv;
    if (up && w == (biosAtE ? 4'd8 : 4'd4)) begin hit = 1; bank = 5'd0; end
    else if (up && sysRomEn && w == 4'd14) begin hit = 1; bank = 5'd1; end
    else if (up && sysRomEn && w == 4'd15) begin hit = 1; bank = 5'd2; end
    else begin
      for (int k = 0; k < 4; k++)
        if (!hit && up && mEn[k] && mIdx[k] == w) begin hit = 1; bank = mBank[k]; end
    end
    serv = hit && (rd || (wr && mWrEn));
    return {serv, serv && wr, serv, hit ? {bank, a[13:0]} : 19'd0};
  endfunction

  task automatic io_write(logic [15:0] port, logic [7:0] d, logic strobeOn = 1'b1);
    @(negedge clk);
    ioAddr = port; ioData = d; ioWr = strobeOn;
    @(negedge clk);
    ioWr = 1'b0;
    if (strobeOn && port >= BASE && port <= BASE + 16'd8) begin
      int o = int'(port - BASE);
      if (o == 8) mWrEn = d[0];
      else if (o[0]) begin mEn[o/2] = d[7]; mIdx[o/2] = d[3:0]; end
      else mBank[o/2] = d[4:0];
    end
  endtask

  task automatic probe(string req, logic [19:0] a, logic rd, logic wr);
    logic [21:0] exp, act;
    @(negedge clk);
    memAddr = a; memRd = rd; memWr = wr;
    #1;
    exp = expect_out(a, rd, wr);
    act = {flashCs, flashWe, decodeAck, flashAddr};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s addr=%h rd=%b wr=%b actual=%h expected=%h", req, a, rd, wr, act, exp);
    end
    @(negedge clk);
    memRd = 0; memWr = 0;
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 4; k++) begin mEn[k] = 0; mIdx[k] = 0; mBank[k] = 0; end
    mWrEn = 0;
    // Dirty registers before reset so reset must clear them
    rstN = 1'b1;
    io_write(BASE + 16'd1, 8'h80);
    io_write(BASE + 16'd8, 8'h01);
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) mEn[k] = 0;
    mWrEn = 0;
    // R1: only fixed mappings; register window idx 0 no longer claims
    probe("R1", 20'hC0010, 1, 0);
    probe("R1", 20'hD1234, 0, 1);
    // R2
    probe("R2", 20'hD3FFF, 1, 0);
    biosAtE = 1;
    probe("R2", 20'hE0000, 1, 0);
    probe("R2", 20'hD0000, 1, 0);
    biosAtE = 0;
    // R3
    probe("R3", 20'hF8001, 1, 0);
    sysRomEn = 1;
    probe("R3", 20'hF8001, 1, 0);
    probe("R3", 20'hFFFFF, 1, 0);
    // R4/R5: window 2 -> index 1 (C4000), bank 17
    io_write(BASE + 16'd4, 8'hF1);
    io_write(BASE + 16'd5, 8'h81);
    probe("R4", 20'hC4ABC, 1, 0);
    probe("R5", 20'hC3FFF, 1, 0);
    // R6: window 0 also on index 1, bank 9; window 1 on BIOS index
    io_write(BASE + 16'd0, 8'h09);
    io_write(BASE + 16'd1, 8'h81);
    probe("R6", 20'hC4000, 1, 0);
    io_write(BASE + 16'd2, 8'h1F);
    io_write(BASE + 16'd3, 8'h84);
    probe("R6", 20'hD0100, 1, 0);
    io_write(BASE + 16'd3, 8'h8F);
    probe("R6", 20'hFC000, 1, 0);
    // R7
    probe("R7", 20'hBFFFF, 1, 0);
    probe("R7", 20'h04000, 1, 0);
    // R8
    probe("R8", 20'hC4010, 0, 1);
    io_write(BASE + 16'd8, 8'h01);
    probe("R8", 20'hC4010, 0, 1);
    // R9: strobe low, out-of-range port
    io_write(BASE + 16'd8, 8'h00, 1'b0);
    probe("R9", 20'hC4020, 0, 1);
    io_write(BASE + 16'd9, 8'h00);
    io_write(BASE - 16'd1, 8'h00);
    probe("R9", 20'hC4020, 0, 1);
    probe("R9", 20'hC4030, 1, 0);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 3) begin
        int p = $urandom_range(0, 10);
        io_write(BASE + 16'(p) - 16'd1, 8'($urandom()));
      end else if (sel == 3) begin
        biosAtE = 1'($urandom()); sysRomEn = 1'($urandom());
      end else begin
        logic [19:0] a = 20'($urandom());
        logic r = 1'($urandom());
        if ($urandom_range(0, 3) != 0) a[19:18] = 2'b11;
        probe("R5_R6_R8_random", a, r, !r);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule